// File: doc/BRIEF.md
# Serial PHY-to-Link Status Transmitter

This block carries status from a serial-bus physical layer to its link layer. It uses a two-bit control code and a two-bit data path, both timed by the system clock. Four kinds of bus event arrive as one-clock pulses: an arbitration reset gap, a subaction gap, the start of a bus reset, and a PHY interrupt. Each pulse sets a sticky flag. Register read responses, which carry an address and data, are held in a one-entry buffer. The block serializes this state into short transfers that carry only the events, or into full 16-bit register transfers. It sends two bits per clock and always starts with the lowest bit pair.

An incoming packet can claim the control lines through the abort input. When that happens, the transfer stops in the same cycle. Event bits that already went out before the abort count as delivered and are cleared. The retry therefore shows them as 0, and it starts again from the first pair. If a gap event is pending, its short transfer goes ahead of a buffered read response.

Top module: `phy_stat_tx`

## Requirements
- R1: While rst_ni is low and directly after reset, ctl_o and d_o are 00 and no flag or read response is pending.
- R2: When only event flags are pending, a short transfer runs for two cycles with ctl_o = 01. Cycle one carries word bits 0,1 and cycle two carries bits 2,3 (d_o[0] holds the even bit). Word bit 0 is the arbitration reset gap, bit 1 the subaction gap, bit 2 the bus reset start and bit 3 the PHY interrupt.
- R3: When a read response is buffered and neither gap flag is set, a long transfer runs for eight cycles with ctl_o = 01. Its word has the event flags in bits 3:0, the register address in bits 7:4 and the register data in bits 15:8.
- R4: Outside a transfer, ctl_o is 00 and d_o is 00. ctl_o never takes any value other than 00 or 01.
- R5: If a read response is buffered and either gap flag is set when a transfer starts, a short transfer goes first and the long transfer follows.
- R6: While abort_i is high, ctl_o and d_o are 00 in that same cycle, and the current transfer is dropped.
- R7: Event bits sent before an abort are cleared, so the retry carries them as 0. Every transfer, retries included, begins with bits 0,1.
- R8: There is at least one idle cycle between two transfers and in the cycle after any cycle with abort_i high. A transfer starts one cycle after the transmitter is idle with work pending and abort_i low.
- R9: Event flags are sticky. A pulse sets its flag, and the flag clears when its bit pair is sent. A pulse that arrives after its pair has gone out in the current transfer is carried in a later transfer.
- R10: The read buffer holds its response until all 16 bits have gone out without an abort. A rd_load_i while the buffer is full is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arb_gap_i | input | 1 | Arbitration reset gap pulse |
| sub_gap_i | input | 1 | Subaction gap pulse |
| bus_rst_i | input | 1 | Bus reset start pulse |
| phy_int_i | input | 1 | PHY interrupt pulse |
| rd_load_i | input | 1 | Load a register read response |
| rd_addr_i | input | ADDR_W | Register address of the response |
| rd_data_i | input | DATA_W | Register data of the response |
| abort_i | input | 1 | Incoming packet claims the control lines |
| ctl_o | output | 2 | Control code: 00 idle, 01 status |
| d_o | output | LANE_W | Status bit pair |

## Verification
Directed patterns isolate each path in turn. Two patterns check the bit order of each transfer form: events alone select the short form, and a read alone selects the long form. A read arriving together with a subaction gap checks the priority choice. An abort in the middle of a long transfer, after its event pair has gone out, separates correct clearing of sent bits and restart from the first pair from a design that resumes part-way or resends stale bits. A second read load while the buffer is full shows whether the held response gets overwritten. A late interrupt pulse in the middle of a transfer shows whether the sticky flag survives. Seeded random pulses, loads and aborts then mix all of these against a cycle model of the requirements.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
  localparam int EV_W = 4;
  localparam logic [3:0] GAP_MASK = 4'b0011;
  localparam logic [1:0] CTL_IDLE = 2'b00;
  localparam logic [1:0] CTL_STAT = 2'b01;
  typedef enum logic {ST_IDLE, ST_SEND} tx_state_e;
endpackage

// File: rtl/phy_stat_flags.sv
module phy_stat_flags
  import phy_stat_pkg::*;
#(
  parameter int LANE_W = 2,
  parameter int BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EV_W-1:0]   set_i,
  input  logic              sent_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [EV_W-1:0]   flags_o
);
  for (genvar i = 0; i < EV_W; i++) begin : g_flag
    localparam int BEAT_OF = i / LANE_W;
    logic flag_q;
    logic clr;
    assign clr = sent_i && (beat_i == BEAT_W'(BEAT_OF));
    // a new pulse wins over clearing in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;
      else if (clr)      flag_q <= 1'b0;
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/phy_stat_rdbuf.sv
module phy_stat_rdbuf #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              done_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!vld_q) begin
      if (load_i) begin
        vld_q  <= 1'b1;
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end else if (done_i) begin
      vld_q <= 1'b0;
    end
  end

  assign vld_o  = vld_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/phy_stat_seq.sv
module phy_stat_seq
  import phy_stat_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANE_W = 2,
  parameter int BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EV_W-1:0]   flags_i,
  input  logic              rd_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              abort_i,
  output logic [1:0]        ctl_o,
  output logic [LANE_W-1:0] d_o,
  output logic              sent_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              rd_done_o
);
  localparam int SHORT_BEATS = EV_W / LANE_W;
  localparam int LONG_BEATS  = WORD_W / LANE_W;
  localparam int IDX_W       = $clog2(WORD_W);

  tx_state_e         state_q;
  logic [BEAT_W-1:0] beat_q;
  logic              long_q;
  logic              pending, start, sending, last;
  logic [WORD_W-1:0] cur_word;
  logic [IDX_W-1:0]  bit_idx;

  assign pending  = (|flags_i) || rd_vld_i;
  assign start    = (state_q == ST_IDLE) && pending && !abort_i;
  assign sending  = (state_q == ST_SEND) && !abort_i;
  assign last     = long_q ? (beat_q == BEAT_W'(LONG_BEATS - 1))
                           : (beat_q == BEAT_W'(SHORT_BEATS - 1));
  assign cur_word = long_q ? word_i : WORD_W'(word_i[EV_W-1:0]);
  assign bit_idx  = IDX_W'(beat_q) * IDX_W'(LANE_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      long_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_SEND;
          beat_q  <= '0;
          // pending gap status goes ahead of a read response
          long_q  <= rd_vld_i && !(|(flags_i & GAP_MASK));
        end
        ST_SEND: begin
          if (abort_i || last) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctl_o     = sending ? CTL_STAT : CTL_IDLE;
  assign d_o       = sending ? cur_word[bit_idx +: LANE_W] : '0;
  assign sent_o    = sending;
  assign beat_o    = beat_q;
  assign rd_done_o = sending && long_q && last;
endmodule

// File: rtl/phy_stat_tx.sv
module phy_stat_tx
  import phy_stat_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LANE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arb_gap_i,
  input  logic              sub_gap_i,
  input  logic              bus_rst_i,
  input  logic              phy_int_i,
  input  logic              rd_load_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              abort_i,
  output logic [1:0]        ctl_o,
  output logic [LANE_W-1:0] d_o
);
  localparam int WORD_W      = EV_W + ADDR_W + DATA_W;
  localparam int SHORT_BEATS = EV_W / LANE_W;
  localparam int LONG_BEATS  = WORD_W / LANE_W;
  localparam int BEAT_W      = $clog2(LONG_BEATS);

  logic [EV_W-1:0]   ev_set, flags;
  logic              sent, rd_done, rd_vld;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [WORD_W-1:0] word;

  assign ev_set = {phy_int_i, bus_rst_i, sub_gap_i, arb_gap_i};
  assign word   = {rd_data, rd_addr, flags};

  phy_stat_flags #(.LANE_W(LANE_W), .BEAT_W(BEAT_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_set),
    .sent_i (sent),
    .beat_i (beat),
    .flags_o(flags)
  );

  phy_stat_rdbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdbuf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(rd_load_i),
    .addr_i(rd_addr_i),
    .data_i(rd_data_i),
    .done_i(rd_done),
    .vld_o (rd_vld),
    .addr_o(rd_addr),
    .data_o(rd_data)
  );

  phy_stat_seq #(.WORD_W(WORD_W), .LANE_W(LANE_W), .BEAT_W(BEAT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_i  (flags),
    .rd_vld_i (rd_vld),
    .word_i   (word),
    .abort_i  (abort_i),
    .ctl_o    (ctl_o),
    .d_o      (d_o),
    .sent_o   (sent),
    .beat_o   (beat),
    .rd_done_o(rd_done)
  );
endmodule

// File: rtl/phy_stat_tx_chk.sv
module phy_stat_tx_chk #(
  parameter int LANE_W      = 2,
  parameter int SHORT_BEATS = 2,
  parameter int LONG_BEATS  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              abort_i,
  input logic [1:0]        ctl_o,
  input logic [LANE_W-1:0] d_o
);
  localparam int RUN_W = $clog2(LONG_BEATS + 1) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               run_q <= '0;
    else if (ctl_o == 2'b01)   run_q <= run_q + 1'b1;
    else                       run_q <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i) !rst_ni |-> (ctl_o == 2'b00 && d_o == '0)); // R1
  AST_CTL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni) (ctl_o == 2'b00 || ctl_o == 2'b01)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (ctl_o == 2'b00) |-> (d_o == '0)); // R4
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) abort_i |-> (ctl_o == 2'b00)); // R6
  AST_POST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) abort_i |=> (ctl_o == 2'b00)); // R8
  AST_RUN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o == 2'b00 && !abort_i && run_q != '0)
      |-> (run_q == RUN_W'(SHORT_BEATS) || run_q == RUN_W'(LONG_BEATS))); // R2
endmodule

bind phy_stat_tx phy_stat_tx_chk #(
  .LANE_W(LANE_W), .SHORT_BEATS(SHORT_BEATS), .LONG_BEATS(LONG_BEATS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .abort_i(abort_i),
  .ctl_o  (ctl_o),
  .d_o    (d_o)
);

// File: tb/tb_phy_stat_tx.sv
module tb_phy_stat_tx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       arb_gap, sub_gap, bus_rst, phy_int, rd_load, abort;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic [1:0] ctl_o, d_o;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [3:0] m_ev;
  logic       m_vld, m_send, m_long;
  logic [3:0] m_addr;
  logic [7:0] m_data;
  int         m_beat;

  always #10 clk = ~clk;

  phy_stat_tx dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .arb_gap_i(arb_gap), .sub_gap_i(sub_gap), .bus_rst_i(bus_rst), .phy_int_i(phy_int),
    .rd_load_i(rd_load), .rd_addr_i(rd_addr), .rd_data_i(rd_data),
    .abort_i(abort), .ctl_o(ctl_o), .d_o(d_o)
  );

  function automatic logic [1:0] exp_pair(input logic [3:0] ev, input logic lng,
                                          input logic [3:0] a, input logic [7:0] dt, input int beat);
    logic [15:0] w;
    w = lng ? {dt, a, ev} : {12'd0, ev};
    return w[2*beat +: 2];
  endfunction

  task automatic check(input string tag, input logic [1:0] c_exp, input logic [1:0] d_exp);
    checks++;
    if (ctl_o !== c_exp || d_o !== d_exp) begin
      errors++;
      $display("FAIL %s ctl=%b d=%b expected ctl=%b d=%b at %0t", tag, ctl_o, d_o, c_exp, d_exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] ev, input logic rq, input logic [3:0] a,
                      input logic [7:0] dt, input logic ab, input string tag);
    logic [1:0] ec, ed;
    logic [3:0] clr;
    logic       snd, last;
    string      t;
    @(negedge clk);
    {phy_int, bus_rst, sub_gap, arb_gap} = ev;
    rd_load = rq; rd_addr = a; rd_data = dt; abort = ab;
    #5;
    snd = m_send && !ab;
    ec  = snd ? 2'b01 : 2'b00;
    ed  = snd ? exp_pair(m_ev, m_long, m_addr, m_data, m_beat) : 2'b00;
    t   = tag;
    if (t == "") t = ab ? "R6" : (m_send ? (m_long ? "R3" : "R2") : "R4");
    check(t, ec, ed);
    // advance the model to the next clock
    clr = 4'd0;
    if (snd && m_beat == 0) clr = 4'b0011;
    if (snd && m_beat == 1) clr = 4'b1100;
    last = m_long ? (m_beat == 7) : (m_beat == 1);
    if (m_vld) begin
      if (snd && m_long && last) m_vld = 1'b0;
    end else if (rq) begin
      m_vld = 1'b1; m_addr = a; m_data = dt;
    end
    if (m_send) begin
      if (ab || last) begin m_send = 1'b0; m_beat = 0; end
      else m_beat++;
    end else if (!ab && (m_ev != 4'd0 || m_vld_prev_hack())) begin
      m_send = 1'b1; m_beat = 0;
      m_long = m_vld_prev && !(m_ev[0] | m_ev[1]);
    end
    m_ev = (m_ev & ~clr) | ev;
    m_vld_prev = m_vld;
  endtask

  // buffer state as seen at the start decision (before this cycle's load)
  logic m_vld_prev;
  function automatic logic m_vld_prev_hack();
    return m_vld_prev;
  endfunction

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(4'd0, 1'b0, 4'd0, 8'd0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] ev;
    process::self().srandom(32'd1234);
    {arb_gap, sub_gap, bus_rst, phy_int, rd_load, abort} = '0;
    rd_addr = '0; rd_data = '0;
    m_ev = '0; m_vld = 1'b0; m_vld_prev = 1'b0; m_send = 1'b0; m_long = 1'b0;
    m_addr = '0; m_data = '0; m_beat = 0;
    repeat (3) @(negedge clk);
    check("R1", 2'b00, 2'b00);
    rst_ni = 1'b1;
    idle(2, "R1");

    // short transfer: arb gap + phy interrupt -> pairs 01, 10
    step(4'b1001, 1'b0, 4'd0, 8'd0, 1'b0, "R2");
    idle(5, "R2");

    // long transfer carrying address A, data 5C
    step(4'd0, 1'b1, 4'hA, 8'h5C, 1'b0, "R3");
    idle(10, "R3");

    // read and subaction gap together: short first, then long
    step(4'b0010, 1'b1, 4'h3, 8'hE7, 1'b0, "R5");
    idle(14, "R5");

    // abort mid long transfer after the bus reset bit went out
    step(4'b0100, 1'b1, 4'h6, 8'h9B, 1'b0, "R7");
    idle(4, "R7");
    step(4'd0, 1'b0, 4'd0, 8'd0, 1'b1, "R6");
    step(4'd0, 1'b0, 4'd0, 8'd0, 1'b1, "R6");
    idle(2, "R8");
    idle(10, "R7");

    // second load while full is ignored
    step(4'd0, 1'b1, 4'h1, 8'h11, 1'b0, "R10");
    step(4'd0, 1'b1, 4'hF, 8'hFF, 1'b0, "R10");
    idle(10, "R10");

    // interrupt pulse after its pair went out stays for the next transfer
    step(4'd0, 1'b1, 4'h2, 8'h44, 1'b0, "R9");
    idle(3, "R9");
    step(4'b1000, 1'b0, 4'd0, 8'd0, 1'b0, "R9");
    idle(12, "R9");

    // seeded random mix
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < 4; b++) ev[b] = ($urandom_range(0, 15) == 0);
      step(ev, $urandom_range(0, 11) == 0, 4'($urandom), 8'($urandom),
           $urandom_range(0, 19) == 0, "");
    end
    idle(20, "");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule